// File: doc/BRIEF.md
# Processor-Side I/O Port with Memory Window Selector

This block holds a small six-bit bidirectional parallel port that sits at the two lowest addresses of a 16-bit processor address space. Address `$0000` holds a direction register, where a 1 makes the matching pin an output. Address `$0001` holds the port data latch. Each pin has its own output enable, so the port can be split between outputs and inputs bit by bit. Three of the pins also act as memory-map controls. Bits 3 to 5 go off chip as plain pins: a tape write line, a tape key sense input (0 = key pressed) and a tape motor control (0 = motor running).

Every processor access also runs through a combinational window selector that names the target of the access. The selector looks at the address, the access direction and the three control bits. Low control bit 0 switches the `$A000`–`$BFFF` window between the interpreter ROM and RAM. Control bit 1 does the same for `$E000`–`$FFFF` and the system ROM. Control bit 2 switches `$D000`–`$DFFF` between device registers and the character ROM. A write into a ROM window always goes to the RAM underneath it. The two port addresses never reach external memory.

Top module: `cpuport_bank`

## Requirements
- R1: A synchronous active-high reset sets the direction register to `6'h2F` and the data latch to `6'h37`. This shows as `pin_oe = 6'h2F` and `pin_out = 6'h37`. Reset takes priority over a write issued in the same cycle.
- R2: A write (`cpu_we = 1`) to `$0000` loads `cpu_wdata[5:0]` into the direction register at the rising clock edge. `pin_oe` shows the new value after that edge. A read of `$0000` returns `{2'b00, direction}`.
- R3: A write to `$0001` loads `cpu_wdata[5:0]` into the data latch at the rising edge. `pin_out` shows the latch value after that edge.
- R4: A read of `$0001` returns, per bit, the latch bit where the direction bit is 1 and `pin_in` where it is 0. Bits 7:6 read as 0.
- R5: A write to any address other than `$0000`/`$0001` leaves the direction register and the data latch unchanged.
- R6: For `$0000` and `$0001`, `region` is 5 (internal port) for both reads and writes.
- R7: A read in `$A000`–`$BFFF` gives `region` 1 (interpreter ROM) when control bit 0 is 1, and 0 (RAM) otherwise.
- R8: A read in `$E000`–`$FFFF` gives `region` 2 (system ROM) when control bit 1 is 1, and 0 (RAM) otherwise.
- R9: In `$D000`–`$DFFF`, control bit 2 = 1 gives `region` 3 (device I/O) for reads and writes. Control bit 2 = 0 gives 4 (character ROM) on reads and 0 (RAM) on writes.
- R10: A write anywhere in `$A000`–`$BFFF` or `$E000`–`$FFFF` gives `region` 0 (RAM), whatever the control bits are.
- R11: A control bit (bits 0–2) whose direction bit is 0 counts as 1 for the window decode, as if pulled high.
- R12: All other addresses give `region` 0 (RAM), and `cpu_rdata` is `8'h00` for every address except the two port addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Write strobe (1 = write, 0 = read) |
| cpu_rdata | output | 8 | Port read data (zero outside the port addresses) |
| pin_in | input | 6 | External pin levels |
| pin_out | output | 6 | Port data latch driven to the pins |
| pin_oe | output | 6 | Per-pin output enable (the direction register) |
| region | output | 3 | Access target: 0 RAM, 1 interpreter ROM, 2 system ROM, 3 device I/O, 4 character ROM, 5 internal port |

## Verification
The port is fully combinational on the read path, so a wrong bit in the direction register or the latch shows up in the same cycle that `$0000` or `$0001` is read. It also shows up straight away on `pin_oe`/`pin_out`, one edge after the bad write. A control bit that latched wrongly, or that is wrongly treated as an input, shows up at the next access into the matching window as a wrong `region` code. The stimulus therefore reads every window back right after each change to the control bits.

// File: rtl/cpuport_pkg.sv
package cpuport_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int PORT_W = 6;
    localparam int CTL_W  = 3;

    localparam logic [PORT_W-1:0] DIR_RST = 6'h2F;
    localparam logic [PORT_W-1:0] DAT_RST = 6'h37;

    // control bit positions inside the port
    localparam int CTL_LANG = 0;
    localparam int CTL_SYS  = 1;
    localparam int CTL_DEV  = 2;

    localparam logic [ADDR_W-1:0] DIR_ADDR = 16'h0000;
    localparam logic [ADDR_W-1:0] DAT_ADDR = 16'h0001;

    typedef enum logic [2:0] {
        RGN_RAM  = 3'd0,
        RGN_LANG = 3'd1,
        RGN_SYS  = 3'd2,
        RGN_DEV  = 3'd3,
        RGN_CHR  = 3'd4,
        RGN_PORT = 3'd5
    } region_e;

    typedef struct packed {
        logic lang;
        logic sys;
        logic dev;
        logic port;
    } window_t;

    function automatic logic in_range(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] lo,
                                      input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic window_t classify(input logic [ADDR_W-1:0] a);
        window_t w;
        w.lang = in_range(a, 16'hA000, 16'hBFFF);
        w.sys  = in_range(a, 16'hE000, 16'hFFFF);
        w.dev  = in_range(a, 16'hD000, 16'hDFFF);
        w.port = (a == DIR_ADDR) || (a == DAT_ADDR);
        return w;
    endfunction

endpackage

// File: rtl/cpuport_regs.sv
module cpuport_regs
    import cpuport_pkg::*;
#(
    parameter int                PW      = PORT_W,
    parameter logic [PW-1:0]     DIR_INI = DIR_RST,
    parameter logic [PW-1:0]     DAT_INI = DAT_RST
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_dir,
    input  logic          wr_dat,
    input  logic [PW-1:0] wval,
    output logic [PW-1:0] dir_q,
    output logic [PW-1:0] dat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_INI;
            dat_q <= DAT_INI;
        end else begin
            if (wr_dir) dir_q <= wval;
            if (wr_dat) dat_q <= wval;
        end
    end

endmodule

// File: rtl/cpuport_rdmux.sv
module cpuport_rdmux
    import cpuport_pkg::*;
#(
    parameter int PW = PORT_W,
    parameter int DW = DATA_W
) (
    input  logic          sel_dir,
    input  logic          sel_dat,
    input  logic [PW-1:0] dir_q,
    input  logic [PW-1:0] dat_q,
    input  logic [PW-1:0] pins,
    output logic [DW-1:0] rdata
);

    localparam int PAD = DW - PW;

    logic [PW-1:0] mixed;

    for (genvar i = 0; i < PW; i++) begin : g_bit
        assign mixed[i] = dir_q[i] ? dat_q[i] : pins[i];
    end

    always_comb begin
        rdata = '0;
        if (sel_dir)
            rdata = {{PAD{1'b0}}, dir_q};
        else if (sel_dat)
            rdata = {{PAD{1'b0}}, mixed};
    end

endmodule

// File: rtl/cpuport_bankdec.sv
module cpuport_bankdec
    import cpuport_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CTL_W
) (
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [CW-1:0] ctl_dir,
    input  logic [CW-1:0] ctl_dat,
    output region_e       region
);

    logic [CW-1:0] ctl_eff;
    window_t       win;

    // an input-configured control bit floats high
    for (genvar i = 0; i < CW; i++) begin : g_ctl
        assign ctl_eff[i] = ctl_dir[i] ? ctl_dat[i] : 1'b1;
    end

    assign win = classify(addr);

    always_comb begin
        region = RGN_RAM;
        if (win.port) begin
            region = RGN_PORT;
        end else if (win.lang) begin
            if (!we && ctl_eff[CTL_LANG]) region = RGN_LANG;
        end else if (win.sys) begin
            if (!we && ctl_eff[CTL_SYS]) region = RGN_SYS;
        end else if (win.dev) begin
            if (ctl_eff[CTL_DEV])
                region = RGN_DEV;
            else if (!we)
                region = RGN_CHR;
        end
    end

endmodule

// File: rtl/cpuport_bank.sv
module cpuport_bank
    import cpuport_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int PW = PORT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_we,
    output logic [DW-1:0] cpu_rdata,
    input  logic [PW-1:0] pin_in,
    output logic [PW-1:0] pin_out,
    output logic [PW-1:0] pin_oe,
    output logic [2:0]    region
);

    logic          sel_dir;
    logic          sel_dat;
    logic [PW-1:0] dir_q;
    logic [PW-1:0] dat_q;
    region_e       rgn;
    logic          unused_wdata_hi;

    assign sel_dir = (cpu_addr == AW'(DIR_ADDR));
    assign sel_dat = (cpu_addr == AW'(DAT_ADDR));
    assign unused_wdata_hi = ^cpu_wdata[DW-1:PW];

    cpuport_regs #(
        .PW      (PW),
        .DIR_INI (PW'(DIR_RST)),
        .DAT_INI (PW'(DAT_RST))
    ) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_dir (cpu_we && sel_dir),
        .wr_dat (cpu_we && sel_dat),
        .wval   (cpu_wdata[PW-1:0]),
        .dir_q  (dir_q),
        .dat_q  (dat_q)
    );

    cpuport_rdmux #(
        .PW (PW),
        .DW (DW)
    ) i_rdmux (
        .sel_dir (sel_dir),
        .sel_dat (sel_dat),
        .dir_q   (dir_q),
        .dat_q   (dat_q),
        .pins    (pin_in),
        .rdata   (cpu_rdata)
    );

    cpuport_bankdec #(
        .AW (AW),
        .CW (CTL_W)
    ) i_dec (
        .addr    (cpu_addr),
        .we      (cpu_we),
        .ctl_dir (dir_q[CTL_W-1:0]),
        .ctl_dat (dat_q[CTL_W-1:0]),
        .region  (rgn)
    );

    assign pin_out = dat_q;
    assign pin_oe  = dir_q;
    assign region  = rgn;

endmodule

// File: rtl/cpuport_bank_chk.sv
module cpuport_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_we,
    input logic [7:0]  cpu_rdata,
    input logic [5:0]  pin_in,
    input logic [5:0]  pin_out,
    input logic [5:0]  pin_oe,
    input logic [2:0]  region
);

    logic in_rom_win;
    logic in_dev_win;
    logic is_port;
    logic dev_ctl;

    assign in_rom_win = (cpu_addr >= 16'hA000 && cpu_addr <= 16'hBFFF) ||
                        (cpu_addr >= 16'hE000);
    assign in_dev_win = (cpu_addr >= 16'hD000 && cpu_addr <= 16'hDFFF);
    assign is_port    = (cpu_addr <= 16'h0001);
    assign dev_ctl    = !pin_oe[2] || pin_out[2];

    AST_RESET_VALUES: assert property (@(posedge clk)
        $past(rst) |-> (pin_oe == 6'h2F && pin_out == 6'h37)); // R1

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == 16'h0000) |=> pin_oe == $past(cpu_wdata[5:0])); // R2

    AST_DAT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr == 16'h0001) |=> pin_out == $past(cpu_wdata[5:0])); // R3

    AST_RDATA_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        cpu_rdata[7:6] == 2'b00); // R4

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cpu_we && is_port) |=> ($stable(pin_out) && $stable(pin_oe))); // R5

    AST_PORT_REGION: assert property (@(posedge clk) disable iff (rst)
        is_port |-> region == 3'd5); // R6

    AST_DEV_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (in_dev_win && dev_ctl) |-> region == 3'd3); // R9

    AST_ROM_WRITE_RAM: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && in_rom_win) |-> region == 3'd0); // R10

    AST_NONPORT_RDATA: assert property (@(posedge clk) disable iff (rst)
        !is_port |-> cpu_rdata == 8'h00); // R12

    logic unused_pins;
    assign unused_pins = ^pin_in;

endmodule

bind cpuport_bank cpuport_bank_chk u_chk (.*);

// File: tb/test_cpuport_bank.sv
module test_cpuport_bank;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_we;
    logic [7:0]  cpu_rdata;
    logic [5:0]  pin_in;
    logic [5:0]  pin_out;
    logic [5:0]  pin_oe;
    logic [2:0]  region;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    cpuport_bank i_cpuport_bank (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_we    (cpu_we),
        .cpu_rdata (cpu_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .region    (region)
    );

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [5:0]  pins;
        logic [2:0]  exp_rgn;
        logic [7:0]  exp_rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;

    // state after reset: direction 2F, latch 37
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 8'h00, 6'h3F, 3'd5, 8'h2F, 4'd2},  // R2 read direction
        '{1'b0, 16'h0001, 8'h00, 6'h3F, 3'd5, 8'h37, 4'd4},  // R4 input bit 4 high
        '{1'b0, 16'h0001, 8'h00, 6'h00, 3'd5, 8'h27, 4'd4},  // R4 input bit 4 low
        '{1'b0, 16'hA123, 8'h00, 6'h00, 3'd1, 8'h00, 4'd7},  // R7 interpreter ROM
        '{1'b0, 16'hE800, 8'h00, 6'h00, 3'd2, 8'h00, 4'd8},  // R8 system ROM
        '{1'b0, 16'hD400, 8'h00, 6'h00, 3'd3, 8'h00, 4'd9},  // R9 device read
        '{1'b1, 16'hA123, 8'h55, 6'h00, 3'd0, 8'h00, 4'd10}, // R10 write under ROM
        '{1'b1, 16'hFFFC, 8'h55, 6'h00, 3'd0, 8'h00, 4'd10}, // R10 write under ROM
        '{1'b1, 16'hD020, 8'h01, 6'h00, 3'd3, 8'h00, 4'd9},  // R9 device write
        '{1'b0, 16'h1234, 8'h00, 6'h00, 3'd0, 8'h00, 4'd12}, // R12 plain RAM
        '{1'b1, 16'h0001, 8'h30, 6'h00, 3'd5, 8'h27, 4'd3},  // R3 clear control bits
        '{1'b0, 16'hA000, 8'h00, 6'h00, 3'd0, 8'h00, 4'd7},  // R7 RAM
        '{1'b0, 16'hE000, 8'h00, 6'h00, 3'd0, 8'h00, 4'd8},  // R8 RAM
        '{1'b0, 16'hDFFF, 8'h00, 6'h00, 3'd4, 8'h00, 4'd9},  // R9 char ROM read
        '{1'b1, 16'hD000, 8'hAA, 6'h00, 3'd0, 8'h00, 4'd9},  // R9 write under char ROM
        '{1'b0, 16'h0001, 8'h00, 6'h00, 3'd5, 8'h20, 4'd3},  // R3 latch readback
        '{1'b1, 16'h0000, 8'hFA, 6'h00, 3'd5, 8'h2F, 4'd2},  // R2 new direction 3A
        '{1'b0, 16'h0000, 8'h00, 6'h00, 3'd5, 8'h3A, 4'd2},  // R2 read new direction
        '{1'b0, 16'h0001, 8'h00, 6'h00, 3'd5, 8'h30, 4'd4},  // R4 mixed, pins low
        '{1'b0, 16'h0001, 8'h00, 6'h05, 3'd5, 8'h35, 4'd4},  // R4 mixed, pins 0,2 high
        '{1'b0, 16'hBFFF, 8'h00, 6'h00, 3'd1, 8'h00, 4'd11}, // R11 input bit 0 as 1
        '{1'b0, 16'hFFFF, 8'h00, 6'h00, 3'd0, 8'h00, 4'd8},  // R8 output bit 1 low
        '{1'b0, 16'hD800, 8'h00, 6'h00, 3'd3, 8'h00, 4'd11}, // R11 input bit 2 as 1
        '{1'b1, 16'hC000, 8'hFF, 6'h00, 3'd0, 8'h00, 4'd12}, // R12 RAM write
        '{1'b0, 16'h0000, 8'h00, 6'h00, 3'd5, 8'h3A, 4'd5},  // R5 direction kept
        '{1'b0, 16'h0001, 8'h00, 6'h00, 3'd5, 8'h30, 4'd5},  // R5 latch kept
        '{1'b0, 16'h0002, 8'h00, 6'h00, 3'd0, 8'h00, 4'd12}, // R12 just above port
        '{1'b1, 16'h0001, 8'hC7, 6'h00, 3'd5, 8'h30, 4'd3},  // R3 latch 07
        '{1'b0, 16'h0001, 8'h00, 6'h00, 3'd5, 8'h02, 4'd4},  // R4 top bits dropped
        '{1'b0, 16'hFFFF, 8'h00, 6'h00, 3'd2, 8'h00, 4'd8},  // R8 system ROM back
        '{1'b0, 16'h9FFF, 8'h00, 6'h00, 3'd0, 8'h00, 4'd12}, // R12 below window
        '{1'b0, 16'hCFFF, 8'h00, 6'h00, 3'd0, 8'h00, 4'd12}  // R12 between windows
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [15:0] a,
                         input logic [7:0] d, input logic [5:0] p);
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = d;
        pin_in    = p;
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b0, 16'h0000, 8'h00, 6'h3F);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state at the pins
        #1;
        check("R1", "pin_oe after reset", {2'b00, pin_oe}, 8'h2F);
        check("R1", "pin_out after reset", {2'b00, pin_out}, 8'h37);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VECS[k].we, VECS[k].addr, VECS[k].wdata, VECS[k].pins);
            #9;
            check($sformatf("R%0d", VECS[k].req), $sformatf("vec %0d region", k),
                  {5'b0, region}, {5'b0, VECS[k].exp_rgn});
            check($sformatf("R%0d", VECS[k].req), $sformatf("vec %0d rdata", k),
                  cpu_rdata, VECS[k].exp_rd);
        end

        // R3 and R2: pins reflect the registers after the vector run
        @(negedge clk);
        drive(1'b0, 16'h2000, 8'h00, 6'h00);
        #1;
        check("R3", "pin_out after writes", {2'b00, pin_out}, 8'h07);
        check("R2", "pin_oe after writes", {2'b00, pin_oe}, 8'h3A);

        // R1 reset wins over a simultaneous port write
        drive(1'b1, 16'h0001, 8'h00, 6'h00);
        rst = 1'b1;
        @(negedge clk);
        drive(1'b1, 16'h0000, 8'h00, 6'h00);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 16'h0001, 8'h00, 6'h10);
        #1;
        check("R1", "pin_out reset over write", {2'b00, pin_out}, 8'h37);
        check("R1", "pin_oe reset over write", {2'b00, pin_oe}, 8'h2F);
        check("R1", "readback after reset", cpu_rdata, 8'h37);

        // R6 write to the port address reports the port, not memory
        drive(1'b1, 16'h0000, 8'h2F, 6'h10);
        #1;
        check("R6", "region on port write", {5'b0, region}, 8'h05);
        @(negedge clk);
        drive(1'b0, 16'h0000, 8'h00, 6'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule